// File: doc/BRIEF.md
# Control-Slot Auxiliary Framer for a Multi-Lane Serial Link

This block builds the per-cycle character stream for a serial link that carries `LANES` characters in each logic clock cycle. A real-time byte presented on a lane always leaves as a data character on that lane one cycle later. A lane with no real-time byte sends a control character instead. That control character comes from a 3-bit selection word. The selection word either marks idle (and the end of an auxiliary packet) or carries two bits of a pending auxiliary packet. The output is a byte and a control flag for each lane, ready for an external 8b/10b encoder.

The two selection-word mappings differ by lane. Lane 0 uses control codes that include commas, so that a receiver can align its logic clock by steering commas into the first position. All other lanes use a mapping with no commas. Auxiliary packets are loaded whole: a left-aligned word and a bit length. The block emits the packet two bits per free control slot, most significant bit first, and then closes it with at least one idle selection word. Real-time traffic is never delayed. Spacing between real-time packets is left to the real-time source, which must leave control slots between its packets.

Top module: `kw_aux_framer`

## Requirements
- R1: While reset is held and on the first cycle after it, every lane outputs the idle control code (lane 0: 0xBC, other lanes: 0x9C) with the control flag set, and `auxReady` is 1.
- R2: A lane whose `rtValid` bit is 1 in a cycle outputs, in the next cycle, the byte from its `rtData` slice (lane i uses bits 8i+7..8i) with the control flag cleared. This holds whatever the auxiliary state is.
- R3: A control character on lane 0 follows this mapping from the selection word: 100 gives 0xBC, 000 gives 0x1C, 001 gives 0x3C, 010 gives 0x5C, and 011 gives 0x7C.
- R4: A control character on any lane other than lane 0 follows this mapping: 100 gives 0x9C, 000 gives 0xF7, 001 gives 0xFB, 010 gives 0xFD, and 011 gives 0xFE. The comma codes 0x3C, 0xBC and 0xFC never appear there.
- R5: Auxiliary bits leave starting at `auxWord` bit AUX_BITS-1 and moving downward. Each control slot carries two bits as selection word 0ab, with a the earlier bit. Within one cycle, lanes are filled in ascending lane order.
- R6: For a packet with an odd bit count, the second bit of its last slot is 0, whatever `auxWord` holds below the packet's length.
- R7: Auxiliary bits advance only in lanes without a real-time byte. A cycle in which every lane carries real-time data leaves the auxiliary packet untouched, and the packet resumes intact later.
- R8: After the last bits of a packet, at least one idle (100) slot goes out before any bit of the next packet. `auxReady` is 0 from the cycle after a load until the cycle in which that idle slot is output.
- R9: `auxLoad` is taken only while `auxReady` is 1. A load offered while `auxReady` is 0 is ignored and changes nothing on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Logic clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rtValid | input | LANES | Real-time byte present on each lane this cycle |
| rtData | input | 8*LANES | Real-time bytes, lane i in bits 8i+7..8i |
| auxLoad | input | 1 | Offer an auxiliary packet |
| auxWord | input | AUX_BITS | Auxiliary packet, left-aligned, first bit in the top bit |
| auxLen | input | $clog2(AUX_BITS+1) | Auxiliary packet length in bits |
| auxReady | output | 1 | A new auxiliary packet can be taken |
| txData | output | 8*LANES | Per-lane character byte, lane i in bits 8i+7..8i |
| txIsK | output | LANES | Per-lane control-character flag |

## Verification
Two functions can land in the same cycle: a real-time byte can take one lane while an auxiliary pair takes another lane, and the last pair of a packet can share a cycle with the idle slot that closes the packet. The bench provokes the first case with patterns where only lane 0 or only lane 1 carries real-time data during a long packet. It provokes the second with packets whose final pair falls on lane 0 and packets whose final pair falls on the last lane, with `auxLoad` held high so that the next packet is offered at the earliest moment. A queue-based reference model predicts every lane's character and `auxReady` on each clock, so any pair that goes to the wrong lane or any missing delimiter shows up as a mismatch.

// File: rtl/kw_aux_pkg.sv
package kw_aux_pkg;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'd0,
    SLOT_DATA = 2'd1,
    SLOT_AUX  = 2'd2
  } slotKindE;

  // Strobes from control to datapath; pairShift supports up to 15 lanes.
  typedef struct packed {
    logic       load;
    logic [3:0] pairShift;
  } auxStrobeT;

  localparam logic [2:0] SEL_IDLE = 3'b100;

  // Selection word to control byte; lead lane may carry commas.
  function automatic logic [7:0] kCode(input logic leadLane, input logic [2:0] sel);
    logic [7:0] code;
    if (sel[2]) begin
      code = leadLane ? 8'hBC : 8'h9C;
    end else if (leadLane) begin
      case (sel[1:0])
        2'b00:   code = 8'h1C;
        2'b01:   code = 8'h3C;
        2'b10:   code = 8'h5C;
        default: code = 8'h7C;
      endcase
    end else begin
      case (sel[1:0])
        2'b00:   code = 8'hF7;
        2'b01:   code = 8'hFB;
        2'b10:   code = 8'hFD;
        default: code = 8'hFE;
      endcase
    end
    return code;
  endfunction

endpackage

// File: rtl/kw_aux_ctrl.sv
module kw_aux_ctrl
  import kw_aux_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int AUX_BITS = 32,
  localparam int LEN_W   = $clog2(AUX_BITS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LANES-1:0]       rtValid,
  input  logic                   auxLoad,
  input  logic [LEN_W-1:0]       auxLen,
  output auxStrobeT              strobe,
  output slotKindE [LANES-1:0]   slotKind,
  output logic                   auxReady
);

  localparam int CW = LEN_W + 1;

  logic [LEN_W-1:0] remBits;
  logic             pendDelim;
  logic [CW-1:0]    used;
  logic [CW-1:0]    twoUsed;
  logic             anyIdle;
  logic             accept;

  assign auxReady = (remBits == '0) && !pendDelim;
  assign accept   = auxLoad && auxReady;

  // Classify every lane: data wins, then pending pairs, then idle.
  always_comb begin
    used    = '0;
    anyIdle = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (rtValid[i]) begin
        slotKind[i] = SLOT_DATA;
      end else if ({used[CW-2:0], 1'b0} < {1'b0, remBits}) begin
        slotKind[i] = SLOT_AUX;
        used        = used + CW'(1);
      end else begin
        slotKind[i] = SLOT_IDLE;
        anyIdle     = 1'b1;
      end
    end
    twoUsed          = {used[CW-2:0], 1'b0};
    strobe.load      = accept;
    strobe.pairShift = 4'(used);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remBits   <= '0;
      pendDelim <= 1'b0;
    end else if (accept) begin
      remBits   <= auxLen;
      pendDelim <= 1'b1;
    end else begin
      if ({1'b0, remBits} > twoUsed) remBits <= LEN_W'({1'b0, remBits} - twoUsed);
      else                           remBits <= '0;
      if (anyIdle) pendDelim <= 1'b0;
    end
  end

endmodule

// File: rtl/kw_aux_dpath.sv
module kw_aux_dpath
  import kw_aux_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int AUX_BITS = 32,
  localparam int LEN_W   = $clog2(AUX_BITS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  auxStrobeT              strobe,
  input  slotKindE [LANES-1:0]   slotKind,
  input  logic [LANES*8-1:0]     rtData,
  input  logic [AUX_BITS-1:0]    auxWord,
  input  logic [LEN_W-1:0]       auxLen,
  output logic [LANES*8-1:0]     txData,
  output logic [LANES-1:0]       txIsK
);

  logic [AUX_BITS-1:0] shReg;
  logic [AUX_BITS-1:0] loadMask;
  logic [3:0]          pairIdx  [LANES];
  logic [7:0]          nextByte [LANES];
  logic                nextK    [LANES];
  logic [7:0]          byteQ    [LANES];
  logic                kQ       [LANES];

  // Keep only the top auxLen bits so odd packets pad with zero.
  assign loadMask = ~({AUX_BITS{1'b1}} >> auxLen);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            shReg <= '0;
    else if (strobe.load) shReg <= auxWord & loadMask;
    else                  shReg <= shReg << {strobe.pairShift, 1'b0};
  end

  // Running count of auxiliary lanes below each lane.
  always_comb begin
    logic [3:0] cnt;
    cnt = '0;
    for (int i = 0; i < LANES; i++) begin
      pairIdx[i] = cnt;
      if (slotKind[i] == SLOT_AUX) cnt = cnt + 4'd1;
    end
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    int         topBit;
    logic [1:0] pairBits;
    logic [2:0] sel;

    assign topBit   = AUX_BITS - 1 - 2 * int'(pairIdx[lane]);
    assign pairBits = (topBit >= 1) ? shReg[topBit -: 2] : 2'b00;
    assign sel      = (slotKind[lane] == SLOT_AUX) ? {1'b0, pairBits} : SEL_IDLE;
    assign nextByte[lane] = (slotKind[lane] == SLOT_DATA) ? rtData[lane*8 +: 8]
                                                          : kCode(lane == 0, sel);
    assign nextK[lane]    = (slotKind[lane] != SLOT_DATA);
    assign txData[lane*8 +: 8] = byteQ[lane];
    assign txIsK[lane]         = kQ[lane];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < LANES; i++) begin
        byteQ[i] <= kCode(i == 0, SEL_IDLE);
        kQ[i]    <= 1'b1;
      end
    end else begin
      for (int i = 0; i < LANES; i++) begin
        byteQ[i] <= nextByte[i];
        kQ[i]    <= nextK[i];
      end
    end
  end

endmodule

// File: rtl/kw_aux_framer.sv
module kw_aux_framer
  import kw_aux_pkg::*;
#(
  parameter int LANES    = 2,
  parameter int AUX_BITS = 32,
  localparam int LEN_W   = $clog2(AUX_BITS + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LANES-1:0]       rtValid,
  input  logic [LANES*8-1:0]     rtData,
  input  logic                   auxLoad,
  input  logic [AUX_BITS-1:0]    auxWord,
  input  logic [LEN_W-1:0]       auxLen,
  output logic                   auxReady,
  output logic [LANES*8-1:0]     txData,
  output logic [LANES-1:0]       txIsK
);

  auxStrobeT            strobe;
  slotKindE [LANES-1:0] slotKind;

  kw_aux_ctrl #(.LANES(LANES), .AUX_BITS(AUX_BITS)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .rtValid  (rtValid),
    .auxLoad  (auxLoad),
    .auxLen   (auxLen),
    .strobe   (strobe),
    .slotKind (slotKind),
    .auxReady (auxReady)
  );

  kw_aux_dpath #(.LANES(LANES), .AUX_BITS(AUX_BITS)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .slotKind (slotKind),
    .rtData   (rtData),
    .auxWord  (auxWord),
    .auxLen   (auxLen),
    .txData   (txData),
    .txIsK    (txIsK)
  );

endmodule

// File: rtl/kw_aux_framer_chk.sv
module kw_aux_framer_chk #(
  parameter int LANES    = 2,
  parameter int AUX_BITS = 32,
  localparam int LEN_W   = $clog2(AUX_BITS + 1)
) (
  input logic                   clk,
  input logic                   rstN,
  input logic [LANES-1:0]       rtValid,
  input logic [LANES*8-1:0]     rtData,
  input logic                   auxLoad,
  input logic [AUX_BITS-1:0]    auxWord,
  input logic [LEN_W-1:0]       auxLen,
  input logic                   auxReady,
  input logic [LANES*8-1:0]     txData,
  input logic [LANES-1:0]       txIsK
);

  logic idleSeen;
  always_comb begin
    idleSeen = 1'b0;
    for (int i = 0; i < LANES; i++) begin
      if (txIsK[i] && txData[i*8 +: 8] == ((i == 0) ? 8'hBC : 8'h9C)) idleSeen = 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    // R2
    rt_lane_data_chk: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(rtValid[g])) |->
        (!txIsK[g] && txData[g*8 +: 8] == $past(rtData[g*8 +: 8])));
    if (g > 0) begin : g_later
      // R4
      later_lane_comma_chk: assert property (@(posedge clk) disable iff (!rstN)
        txIsK[g] |-> !(txData[g*8 +: 8] inside {8'h3C, 8'hBC, 8'hFC}));
    end
  end

  // R3
  lead_lane_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    txIsK[0] |-> (txData[7:0] inside {8'hBC, 8'h1C, 8'h3C, 8'h5C, 8'h7C}));

  // R9
  aux_load_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (auxLoad && auxReady) |=> !auxReady);

  // R8
  ready_fall_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(auxReady) && $past(rstN)) |-> $past(auxLoad));

  // R8
  ready_rise_delim_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(auxReady) && $past(rstN)) |-> idleSeen);

  // R7
  all_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&rtValid && !auxLoad) |=> $stable(auxReady));

endmodule

bind kw_aux_framer kw_aux_framer_chk #(.LANES(LANES), .AUX_BITS(AUX_BITS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .rtValid  (rtValid),
  .rtData   (rtData),
  .auxLoad  (auxLoad),
  .auxWord  (auxWord),
  .auxLen   (auxLen),
  .auxReady (auxReady),
  .txData   (txData),
  .txIsK    (txIsK)
);

// File: tb/sim_kw_aux_framer.sv
module sim_kw_aux_framer;

  localparam int LANES    = 2;
  localparam int AUX_BITS = 32;
  localparam int LEN_W    = $clog2(AUX_BITS + 1);

  logic clk  = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic [LANES-1:0]    rtValid = '0;
  logic [LANES*8-1:0]  rtData  = '0;
  logic                auxLoad = 1'b0;
  logic [AUX_BITS-1:0] auxWord = '0;
  logic [LEN_W-1:0]    auxLen  = '0;
  logic                auxReady;
  logic [LANES*8-1:0]  txData;
  logic [LANES-1:0]    txIsK;

  kw_aux_framer #(.LANES(LANES), .AUX_BITS(AUX_BITS)) u0 (
    .clk(clk), .rstN(rstN), .rtValid(rtValid), .rtData(rtData),
    .auxLoad(auxLoad), .auxWord(auxWord), .auxLen(auxLen),
    .auxReady(auxReady), .txData(txData), .txIsK(txIsK)
  );

  int    checks   = 0;
  int    failures = 0;
  bit    done     = 0;
  bit    bitQ[$];
  bit    pendM    = 0;
  logic [7:0] expData [LANES];
  logic       expK    [LANES];
  bit    expReady = 1;
  string expTag   = "R1";

  function automatic logic [7:0] refCode(int lane, logic [2:0] sel);
    if (sel == 3'b100) return (lane == 0) ? 8'hBC : 8'h9C;
    if (lane == 0) begin
      if (sel[1:0] == 2'b00) return 8'h1C;
      if (sel[1:0] == 2'b01) return 8'h3C;
      if (sel[1:0] == 2'b10) return 8'h5C;
      return 8'h7C;
    end
    if (sel[1:0] == 2'b00) return 8'hF7;
    if (sel[1:0] == 2'b01) return 8'hFB;
    if (sel[1:0] == 2'b10) return 8'hFD;
    return 8'hFE;
  endfunction

  task automatic checkVal(string tag, string what, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, actual, expected);
    end
  endtask

  task automatic compareOutputs();
    for (int l = 0; l < LANES; l++) begin
      string tag;
      if (expTag != "") tag = expTag;
      else if (!expK[l]) tag = "R2";
      else tag = (l == 0) ? "R3" : "R4";
      checkVal(tag, $sformatf("lane%0d {k,byte}", l),
               int'({txIsK[l], txData[l*8 +: 8]}), int'({expK[l], expData[l]}));
    end
    checkVal((expTag != "") ? expTag : "R8", "auxReady", int'(auxReady), int'(expReady));
  endtask

  // Behavioural reference: bit queue plus pending-delimiter flag.
  task automatic modelStep(string tag);
    bit readyNow;
    bit idle;
    readyNow = !(bitQ.size() > 0 || pendM);
    idle = 0;
    for (int l = 0; l < LANES; l++) begin
      if (rtValid[l]) begin
        expData[l] = rtData[l*8 +: 8];
        expK[l]    = 1'b0;
      end else if (bitQ.size() > 0) begin
        bit a, b;
        a = bitQ.pop_front();
        b = (bitQ.size() > 0) ? bitQ.pop_front() : 1'b0;
        expData[l] = refCode(l, {1'b0, a, b});
        expK[l]    = 1'b1;
      end else begin
        expData[l] = refCode(l, 3'b100);
        expK[l]    = 1'b1;
        idle = 1;
      end
    end
    if (idle) pendM = 0;
    if (auxLoad && readyNow) begin
      for (int j = 0; j < int'(auxLen); j++) bitQ.push_back(auxWord[AUX_BITS-1-j]);
      pendM = 1;
    end
    expReady = !(bitQ.size() > 0 || pendM);
    expTag   = tag;
  endtask

  task automatic cycle(input logic [LANES-1:0] v, input logic [LANES*8-1:0] d,
                       input logic ld, input logic [AUX_BITS-1:0] w,
                       input logic [LEN_W-1:0] len, input string tag);
    @(negedge clk);
    compareOutputs();
    rtValid = v;
    rtData  = d;
    auxLoad = ld;
    auxWord = w;
    auxLen  = len;
    modelStep(tag);
  endtask

  task automatic idleCycles(int n, string tag);
    for (int i = 0; i < n; i++) cycle('0, '0, 1'b0, '0, '0, tag);
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) begin
      expData[l] = refCode(l, 3'b100);
      expK[l]    = 1'b1;
    end
    repeat (3) @(posedge clk);
    // R1: outputs under reset
    @(negedge clk);
    compareOutputs();
    rstN = 1'b1;

    // R1: first cycles after reset
    idleCycles(2, "R1");

    // R5: ordered pairs, lanes filled in ascending order
    cycle('0, '0, 1'b1, 32'hB400_0000, 6'd8, "R5");
    idleCycles(4, "R5");

    // R6: odd length, garbage below the length must not leak
    cycle('0, '0, 1'b1, 32'hE7FF_FFFF, 6'd5, "R6");
    idleCycles(4, "R6");

    // R7: real-time data holds aux bits back, then mixed lanes
    cycle('0, '0, 1'b1, 32'hC3A5_0000, 6'd16, "R7");
    cycle(2'b11, 16'h1122, 1'b0, '0, '0, "R7");
    cycle(2'b11, 16'h3344, 1'b0, '0, '0, "R7");
    cycle(2'b11, 16'h5566, 1'b0, '0, '0, "R7");
    cycle(2'b01, 16'h0077, 1'b0, '0, '0, "R7");
    cycle(2'b10, 16'h8800, 1'b0, '0, '0, "R7");
    cycle(2'b01, 16'h0099, 1'b0, '0, '0, "R7");
    idleCycles(6, "R7");

    // R9: load offered while busy is ignored
    cycle('0, '0, 1'b1, 32'hA5A0_0000, 6'd12, "R9");
    cycle('0, '0, 1'b1, 32'h5555_5555, 6'd32, "R9");
    cycle('0, '0, 1'b1, 32'hFFFF_FFFF, 6'd32, "R9");
    idleCycles(5, "R9");

    // R8: back-to-back offers; last pair on last lane, then on lane 0
    cycle('0, '0, 1'b1, 32'hF000_0000, 6'd4, "R8");
    for (int i = 0; i < 6; i++) cycle('0, '0, 1'b1, 32'h6000_0000, 6'd4, "R8");
    for (int i = 0; i < 6; i++) cycle('0, '0, 1'b1, 32'hD000_0000, 6'd6, "R8");
    cycle(2'b10, 16'hAB00, 1'b1, 32'h9000_0000, 6'd2, "R8");
    idleCycles(4, "R8");

    // Mixed random traffic, lane-based requirement tags
    for (int i = 0; i < 400; i++) begin
      logic [LANES-1:0]   v;
      logic [LANES*8-1:0] d;
      logic               ld;
      logic [LEN_W-1:0]   len;
      v   = LANES'($urandom);
      d   = (LANES*8)'($urandom);
      ld  = ($urandom % 3) == 0;
      len = LEN_W'(1 + ($urandom % AUX_BITS));
      cycle(v, d, ld, AUX_BITS'($urandom), len, "");
    end
    idleCycles(20, "");
    @(negedge clk);
    compareOutputs();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule